// File: doc/BRIEF.md
# Word-Serial Register Access Bridge

This block sits on the target side of a narrow host link and gives the host access to a 24-bit register space through a single 32-bit transfer port, plus a separate status register. The host starts each access by writing a command word into the transfer port. The top byte of that word is an opcode and the low 24 bits are a register address. A write command takes one more word on the same port, which is the value to store. The bridge then performs one transaction on a simple back-end register bus. That bus has a request, a write enable, an address, write data, read data and a single-cycle acknowledge.

When the transaction ends, the bridge raises a ready bit in the status register. The host then reads the transfer port to collect the response. It always gets a status word first. For a read command it then gets the register value as a second word. Ready falls once the host has collected every pending word. A host that finds ready already set can clear out leftover words by reading the port until ready drops.

A back end that never answers is cut off after a configurable number of cycles. Unknown opcodes are answered without touching the back end. A command that arrives while an earlier one is still in flight or unread is dropped, and the drop is reported in the next status word.

Top module: `word_serial_bridge`

## Requirements
- R1: A command word carries the opcode in bits 31:24 and the register address in bits 23:0. While a request is outstanding, `be_addr`, `be_we` and `be_wdata` hold the values of that command.
- R2: Opcode 0x10 does not start a back-end access on its own. The next write to the transfer port is taken as the data word, and then one back-end write (`be_we`=1) of that data goes to the commanded address.
- R3: `be_req` stays high until `be_ack` or until it has been high for TMO_CYCLES cycles, whichever comes first. In the second case the status word has bit 0 set and, for a read, the value word is 0.
- R4: Bit 0 of `stat_reg` is the ready flag and all other bits of `stat_reg` read 0. Ready is low after reset and goes high in the cycle after the back-end access completes.
- R5: While ready is high, the first word on `xfer_rdata` is a status word. Bit 0 = timeout, bit 1 = unknown opcode, bit 2 = overrun, and all other bits are 0. A clean access gives 0.
- R6: For opcode 0x01, a second word follows the status word: the value that `be_rdata` carried with `be_ack`.
- R7: Each `xfer_rd` pulse while ready is high consumes the word shown on `xfer_rdata`, and ready falls after the last word. While ready is low, `xfer_rdata` is 0 and `xfer_rd` has no effect. Leftover words can be drained by reading the port.
- R8: An opcode other than 0x01 or 0x10 produces a one-word response with status bit 1 set and raises no `be_req`.
- R9: A transfer-port write while an access is outstanding or a response is unread is dropped, without any back-end request. It sets the overrun bit, which shows in status words until a status word carrying it has been read.
- R10: `be_req` is never high while ready is high, and each accepted command raises `be_req` at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_wr | input | 1 | Write strobe for the transfer port |
| xfer_wdata | input | DATA_W | Word written into the transfer port |
| xfer_rd | input | 1 | Read strobe; consumes the shown response word |
| xfer_rdata | output | DATA_W | Response word currently shown on the transfer port |
| stat_reg | output | DATA_W | Status register; bit 0 is ready |
| be_req | output | 1 | Back-end request |
| be_we | output | 1 | Back-end write enable |
| be_addr | output | ADDR_W | Back-end register address |
| be_wdata | output | DATA_W | Back-end write data |
| be_rdata | input | DATA_W | Back-end read data, valid with acknowledge |
| be_ack | input | 1 | Back-end single-cycle acknowledge |

## Verification
The bench builds the bridge with TMO_CYCLES set to 16 and keeps the default 32-bit word and 24-bit address. The short window makes the timeout path reachable in a few cycles, so its exact length can be counted at the ports. At 16 cycles it is also clearly separated from the slow acknowledges, up to six cycles, that the bench's register model produces. Setting the top address bit makes that model stay silent, which drives both read and write commands into the timeout.

// File: rtl/wsb_pkg.sv
package wsb_pkg;

  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h10;

  localparam int SB_TMO   = 0;
  localparam int SB_BADOP = 1;
  localparam int SB_OVR   = 2;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WDATA,
    HS_BUSY,
    HS_RESP
  } host_st_e;

endpackage

// File: rtl/wsb_cmd_dec.sv
module wsb_cmd_dec #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic [DATA_W-1:0] cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              is_rd,
  output logic              is_wr,
  output logic              is_bad
);
  import wsb_pkg::*;

  localparam int OP_W = DATA_W - ADDR_W;

  logic [OP_W-1:0] op;

  assign op     = cmd[DATA_W-1:ADDR_W];
  assign addr   = cmd[ADDR_W-1:0];
  assign is_rd  = (op == OP_W'(OP_READ));
  assign is_wr  = (op == OP_W'(OP_WRITE));
  assign is_bad = !(is_rd || is_wr);

endmodule

// File: rtl/wsb_be_seq.sv
module wsb_be_seq #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int TMO_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic              be_ack,
  input  logic [DATA_W-1:0] be_rdata,
  output logic              be_req,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  output logic              done,
  output logic              done_tmo,
  output logic [DATA_W-1:0] done_rdata
);

  localparam int CNT_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;

  assign done       = busy_q && (be_ack || (cnt_q == CNT_LAST));
  assign done_tmo   = busy_q && !be_ack;
  assign done_rdata = be_ack ? be_rdata : '0;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (start) begin
      we_q   <= start_we;
      addr_q <= start_addr;
      wd_q   <= start_wdata;
    end
  end

  assign be_req   = busy_q;
  assign be_we    = we_q;
  assign be_addr  = addr_q;
  assign be_wdata = wd_q;

endmodule

// File: rtl/wsb_resp_buf.sv
module wsb_resp_buf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_two,
  input  logic              load_tmo,
  input  logic              load_bad,
  input  logic [DATA_W-1:0] load_val,
  input  logic              pop,
  input  logic              ovr_set,
  output logic              ready,
  output logic              last,
  output logic [DATA_W-1:0] head
);
  import wsb_pkg::*;

  logic [1:0]        cnt_q, cnt_d;
  logic              stat_next_q, stat_next_d;
  logic              tmo_q, bad_q, ovr_q, ovr_d;
  logic [DATA_W-1:0] val_q;
  logic [DATA_W-1:0] stat_word;
  logic              pop_ok;

  assign ready  = (cnt_q != 2'd0);
  assign last   = (cnt_q == 2'd1);
  assign pop_ok = pop && ready;

  always_comb begin
    stat_word            = '0;
    stat_word[SB_TMO]    = tmo_q;
    stat_word[SB_BADOP]  = bad_q;
    stat_word[SB_OVR]    = ovr_q;
  end

  assign head = !ready ? '0 : (stat_next_q ? stat_word : val_q);

  always_comb begin
    cnt_d       = cnt_q;
    stat_next_d = stat_next_q;
    if (load) begin
      cnt_d       = load_two ? 2'd2 : 2'd1;
      stat_next_d = 1'b1;
    end else if (pop_ok) begin
      cnt_d       = cnt_q - 2'd1;
      stat_next_d = 1'b0;
    end
  end

  always_comb begin
    ovr_d = ovr_q;
    if (ovr_set) begin
      ovr_d = 1'b1;
    end else if (pop_ok && stat_next_q) begin
      ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= 2'd0;
      stat_next_q <= 1'b0;
      ovr_q       <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      stat_next_q <= stat_next_d;
      ovr_q       <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q <= 1'b0;
      bad_q <= 1'b0;
      val_q <= '0;
    end else if (load) begin
      tmo_q <= load_tmo;
      bad_q <= load_bad;
      val_q <= load_val;
    end
  end

endmodule

// File: rtl/word_serial_bridge.sv
module word_serial_bridge #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int TMO_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_wr,
  input  logic [DATA_W-1:0] xfer_wdata,
  input  logic              xfer_rd,
  output logic [DATA_W-1:0] xfer_rdata,
  output logic [DATA_W-1:0] stat_reg,
  output logic              be_req,
  output logic              be_we,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic              be_ack
);
  import wsb_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  logic [ADDR_W-1:0] dec_addr;
  logic              dec_rd, dec_wr, dec_bad;

  wsb_cmd_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .cmd    (xfer_wdata),
    .addr   (dec_addr),
    .is_rd  (dec_rd),
    .is_wr  (dec_wr),
    .is_bad (dec_bad)
  );

  host_st_e          st_q, st_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_en;
  logic              seq_start, seq_we;
  logic [ADDR_W-1:0] seq_addr;
  logic [DATA_W-1:0] seq_wdata;
  logic              seq_done, seq_tmo;
  logic [DATA_W-1:0] seq_rdata;
  logic              rb_load, rb_two, rb_tmo, rb_bad;
  logic [DATA_W-1:0] rb_val;
  logic              rb_ready, rb_last;
  logic              ovr_set;

  wsb_be_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (seq_start),
    .start_we    (seq_we),
    .start_addr  (seq_addr),
    .start_wdata (seq_wdata),
    .be_ack      (be_ack),
    .be_rdata    (be_rdata),
    .be_req      (be_req),
    .be_we       (be_we),
    .be_addr     (be_addr),
    .be_wdata    (be_wdata),
    .done        (seq_done),
    .done_tmo    (seq_tmo),
    .done_rdata  (seq_rdata)
  );

  wsb_resp_buf #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (rb_load),
    .load_two (rb_two),
    .load_tmo (rb_tmo),
    .load_bad (rb_bad),
    .load_val (rb_val),
    .pop      (xfer_rd),
    .ovr_set  (ovr_set),
    .ready    (rb_ready),
    .last     (rb_last),
    .head     (xfer_rdata)
  );

  assign ovr_set = xfer_wr && ((st_q == HS_BUSY) || (st_q == HS_RESP));

  always_comb begin
    st_d      = st_q;
    pend_en   = 1'b0;
    seq_start = 1'b0;
    seq_we    = 1'b0;
    seq_addr  = dec_addr;
    seq_wdata = '0;
    rb_load   = 1'b0;
    rb_two    = 1'b0;
    rb_tmo    = 1'b0;
    rb_bad    = 1'b0;
    rb_val    = '0;
    case (st_q)
      HS_IDLE: begin
        if (xfer_wr) begin
          if (dec_rd) begin
            seq_start = 1'b1;
            st_d      = HS_BUSY;
          end else if (dec_wr) begin
            pend_en   = 1'b1;
            st_d      = HS_WDATA;
          end else if (dec_bad) begin
            rb_load   = 1'b1;
            rb_bad    = 1'b1;
            st_d      = HS_RESP;
          end
        end
      end
      HS_WDATA: begin
        if (xfer_wr) begin
          seq_start = 1'b1;
          seq_we    = 1'b1;
          seq_addr  = pend_addr_q;
          seq_wdata = xfer_wdata;
          st_d      = HS_BUSY;
        end
      end
      HS_BUSY: begin
        if (seq_done) begin
          rb_load = 1'b1;
          rb_two  = !be_we;
          rb_tmo  = seq_tmo;
          rb_val  = seq_rdata;
          st_d    = HS_RESP;
        end
      end
      HS_RESP: begin
        if (xfer_rd && rb_last) begin
          st_d = HS_IDLE;
        end
      end
      default: st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      st_q <= HS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pend_addr_q <= '0;
    end else if (pend_en) begin
      pend_addr_q <= dec_addr;
    end
  end

  assign stat_reg = {{(DATA_W-1){1'b0}}, rb_ready};

endmodule

// File: rtl/wsb_chk.sv
module wsb_chk #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int TMO_CYCLES = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] xfer_rdata,
  input logic [DATA_W-1:0] stat_reg,
  input logic              be_req,
  input logic              be_we,
  input logic [ADDR_W-1:0] be_addr,
  input logic [DATA_W-1:0] be_wdata,
  input logic              be_ack
);

  int unsigned req_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_run <= 0;
    end else if (be_req) begin
      req_run <= req_run + 1;
    end else begin
      req_run <= 0;
    end
  end

  a_r3_req_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> (req_run < TMO_CYCLES));

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack && (req_run < TMO_CYCLES - 1)) |=> be_req);

  a_r1_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_ack) |=>
      (!be_req || ($stable(be_addr) && $stable(be_we) && $stable(be_wdata))));

  a_r10_no_req_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    stat_reg[0] |-> !be_req);

  a_r4_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && be_ack) |=> stat_reg[0]);

  a_r7_quiet_port: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_reg[0] |-> (xfer_rdata == '0));

endmodule

bind word_serial_bridge wsb_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_rdata (xfer_rdata),
  .stat_reg   (stat_reg),
  .be_req     (be_req),
  .be_we      (be_we),
  .be_addr    (be_addr),
  .be_wdata   (be_wdata),
  .be_ack     (be_ack)
);

// File: tb/word_serial_bridge_tb.sv
`timescale 1ns/1ps
module word_serial_bridge_tb;

  localparam int DW  = 32;
  localparam int AW  = 24;
  localparam int TMO = 16;

  logic          clk;
  logic          rst_n;
  logic          xfer_wr;
  logic [DW-1:0] xfer_wdata;
  logic          xfer_rd;
  logic [DW-1:0] xfer_rdata;
  logic [DW-1:0] stat_reg;
  logic          be_req;
  logic          be_we;
  logic [AW-1:0] be_addr;
  logic [DW-1:0] be_wdata;
  logic [DW-1:0] be_rdata;
  logic          be_ack;

  int errors = 0;
  int checks = 0;
  bit model_on = 0;

  word_serial_bridge #(.DATA_W(DW), .ADDR_W(AW), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .xfer_wr(xfer_wr), .xfer_wdata(xfer_wdata),
    .xfer_rd(xfer_rd), .xfer_rdata(xfer_rdata),
    .stat_reg(stat_reg),
    .be_req(be_req), .be_we(be_we), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata), .be_ack(be_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Back-end register model: 16 words, silent when address bit 23 is set.
  logic [DW-1:0] mem [16];
  int            lat = 0;
  int            lat_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_ack   <= 1'b0;
      be_rdata <= '0;
      lat_cnt  <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i;
    end else if (be_req && !be_ack && !be_addr[23]) begin
      if (lat_cnt >= lat) begin
        be_ack   <= 1'b1;
        lat_cnt  <= 0;
        be_rdata <= mem[be_addr[3:0]];
        if (be_we) mem[be_addr[3:0]] <= be_wdata;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      be_ack <= 1'b0;
    end
  end

  // Port monitor
  int            req_rises = 0;
  int            req_run = 0;
  int            last_run = 0;
  bit            req_prev = 0;
  logic [AW-1:0] last_addr = '0;
  logic          last_we = 1'b0;
  logic [DW-1:0] last_wd = '0;

  always @(posedge clk) begin
    if (be_req) begin
      if (!req_prev) begin
        req_rises = req_rises + 1;
        req_run   = 1;
      end else begin
        req_run = req_run + 1;
      end
      last_run  = req_run;
      last_addr = be_addr;
      last_we   = be_we;
      last_wd   = be_wdata;
    end
    req_prev = be_req;
  end

  // Behavioural reference model
  int          m_st = 0;
  int          m_cnt = 0;
  bit          m_we = 0;
  bit          m_ovr = 0;
  int unsigned m_addr = 0;
  int unsigned m_wd = 0;
  bit          q_stat [$];
  int unsigned q_val  [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ovr = 0;
      q_stat.delete(); q_val.delete();
    end else begin
      bit set_ovr;
      set_ovr = 0;
      case (m_st)
        0: if (xfer_wr) begin
             if (xfer_wdata[31:24] == 8'h01) begin
               m_st = 2; m_we = 0; m_addr = xfer_wdata[23:0]; m_cnt = 0;
             end else if (xfer_wdata[31:24] == 8'h10) begin
               m_st = 1; m_addr = xfer_wdata[23:0];
             end else begin
               q_stat.push_back(1); q_val.push_back(2); m_st = 3;
             end
           end
        1: if (xfer_wr) begin
             m_st = 2; m_we = 1; m_wd = xfer_wdata; m_cnt = 0;
           end
        2: begin
             if (xfer_wr) set_ovr = 1;
             if (be_ack || m_cnt == TMO - 1) begin
               q_stat.push_back(1); q_val.push_back(be_ack ? 0 : 1);
               if (!m_we) begin
                 q_stat.push_back(0); q_val.push_back(be_ack ? be_rdata : 0);
               end
               m_st = 3;
             end else begin
               m_cnt++;
             end
           end
        default: begin
             if (xfer_wr) set_ovr = 1;
             if (xfer_rd) begin
               if (q_stat[0] && !set_ovr) m_ovr = 0;
               void'(q_stat.pop_front()); void'(q_val.pop_front());
               if (q_stat.size() == 0) m_st = 0;
             end
           end
      endcase
      if (set_ovr) m_ovr = 1;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      logic [DW-1:0] exp_rd;
      bit            exp_rdy;
      exp_rdy = (q_stat.size() != 0);
      exp_rd  = '0;
      if (exp_rdy) exp_rd = q_stat[0] ? (q_val[0] | (m_ovr ? 32'd4 : 32'd0)) : q_val[0];
      check(stat_reg == {31'b0, exp_rdy}, "R4 model ready", stat_reg, {31'b0, exp_rdy});
      check(xfer_rdata == exp_rd, "R5 model port word", xfer_rdata, exp_rd);
      check(be_req == (m_st == 2), "R10 model request", {31'b0, be_req}, {31'b0, m_st == 2});
      if (m_st == 2) begin
        check(be_addr == m_addr[23:0], "R1 model address", {8'b0, be_addr}, m_addr);
        check(be_we == m_we, "R2 model write enable", {31'b0, be_we}, {31'b0, m_we});
        if (m_we) check(be_wdata == m_wd, "R2 model write data", be_wdata, m_wd);
      end
    end
  end

  // Host-side tasks
  task automatic host_wr(input logic [DW-1:0] w);
    @(negedge clk);
    xfer_wr = 1'b1; xfer_wdata = w;
    @(negedge clk);
    xfer_wr = 1'b0; xfer_wdata = '0;
  endtask

  task automatic host_rd(output logic [DW-1:0] w);
    @(negedge clk);
    w = xfer_rdata;
    xfer_rd = 1'b1;
    @(negedge clk);
    xfer_rd = 1'b0;
  endtask

  task automatic wait_rdy(input string req);
    int n;
    n = 0;
    while (!stat_reg[0] && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(stat_reg[0] == 1'b1, req, stat_reg, 32'd1);
  endtask

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    int r0;
    rst_n = 1'b0; xfer_wr = 1'b0; xfer_rd = 1'b0; xfer_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1;

    // Reset state
    check(stat_reg == 0, "R4 reset ready low", stat_reg, 0);
    check(xfer_rdata == 0, "R7 reset port quiet", xfer_rdata, 0);
    check(be_req == 0, "R10 reset no request", {31'b0, be_req}, 0);

    // Write command with data word
    lat = 0;
    host_wr({8'h10, 24'h000103});
    check(be_req == 0, "R2 waits for data word", {31'b0, be_req}, 0);
    host_wr(32'hA5A5_0001);
    wait_rdy("R4 ready after write");
    check(last_we == 1'b1 && last_wd == 32'hA5A5_0001, "R2 back-end write data", last_wd, 32'hA5A5_0001);
    check(last_addr == 24'h000103, "R1 write address", {8'b0, last_addr}, 32'h103);
    host_rd(w);
    check(w == 0, "R5 clean write status", w, 0);
    check(stat_reg[0] == 1'b0, "R7 ready low after single word", stat_reg, 0);
    check(mem[3] == 32'hA5A5_0001, "R2 register updated", mem[3], 32'hA5A5_0001);

    // Read command with slow acknowledge
    lat = 3;
    host_wr({8'h01, 24'h0ABCD3});
    wait_rdy("R4 ready after read");
    host_rd(w);
    check(w == 0, "R5 clean read status", w, 0);
    host_rd(w);
    check(w == 32'hA5A5_0001, "R6 read value", w, 32'hA5A5_0001);
    check(last_addr == 24'h0ABCD3, "R1 read address", {8'b0, last_addr}, 32'h0ABCD3);
    check(stat_reg[0] == 1'b0, "R7 ready low after two words", stat_reg, 0);

    // Unknown opcode
    r0 = req_rises;
    host_wr({8'h7F, 24'h000003});
    wait_rdy("R8 ready on bad opcode");
    host_rd(w);
    check(w == 32'd2, "R8 bad opcode status", w, 2);
    check(stat_reg[0] == 1'b0, "R8 single word response", stat_reg, 0);
    check(req_rises == r0, "R8 no back-end request", req_rises, r0);

    // Read timeout
    host_wr({8'h01, 24'h800005});
    wait_rdy("R3 ready after timeout");
    check(last_run == TMO, "R3 request window length", last_run, TMO);
    host_rd(w);
    check(w == 32'd1, "R3 timeout status", w, 1);
    host_rd(w);
    check(w == 0, "R3 timeout value zero", w, 0);

    // Write timeout
    host_wr({8'h10, 24'h800001});
    host_wr(32'hDEAD_BEEF);
    wait_rdy("R3 ready after write timeout");
    host_rd(w);
    check(w == 32'd1, "R3 write timeout status", w, 1);
    check(stat_reg[0] == 1'b0, "R3 write timeout single word", stat_reg, 0);

    // Overrun while busy
    lat = 6;
    r0 = req_rises;
    host_wr({8'h01, 24'h000003});
    host_wr({8'h01, 24'h000004});
    wait_rdy("R9 ready after overrun");
    host_rd(w);
    check(w == 32'd4, "R9 overrun flagged", w, 4);
    host_rd(w);
    check(w == 32'hA5A5_0001, "R9 first command served", w, 32'hA5A5_0001);
    check(req_rises == r0 + 1, "R9 dropped command no access", req_rises, r0 + 1);
    host_wr({8'h01, 24'h000004});
    wait_rdy("R9 ready after clean read");
    host_rd(w);
    check(w == 0, "R9 overrun cleared", w, 0);
    host_rd(w);
    check(w == 32'h1000_0004, "R6 reset contents read", w, 32'h1000_0004);

    // Drain of stale words
    lat = 1;
    host_wr({8'h01, 24'h000003});
    wait_rdy("R7 ready before drain");
    host_wr({8'h01, 24'h000005});
    host_rd(w);
    check(w == 32'd4, "R7 drain first word", w, 4);
    host_rd(w);
    check(w == 32'hA5A5_0001, "R7 drain second word", w, 32'hA5A5_0001);
    check(stat_reg[0] == 1'b0, "R7 drained", stat_reg, 0);

    // Reads while idle have no effect
    for (int i = 0; i < 3; i++) host_rd(w);
    check(w == 0 && stat_reg == 0, "R7 idle reads ignored", w, 0);
    lat = 2;
    host_wr({8'h10, 24'h000007});
    host_wr(32'h1234_5678);
    wait_rdy("R4 ready after second write");
    host_rd(w);
    check(w == 0, "R5 second write status", w, 0);
    host_wr({8'h01, 24'h000007});
    wait_rdy("R4 ready after readback");
    host_rd(w);
    check(w == 0, "R5 readback status", w, 0);
    host_rd(w);
    check(w == 32'h1234_5678, "R6 readback value", w, 32'h1234_5678);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule